// File: doc/BRIEF.md
# LCD Scan Clock Divider

This block turns a stream of count events into the scan clock for an LCD controller. A control bit picks where the count events come from. One choice is a one-cycle enable from a clock prescaler. The other is the rising edge of one bit of a neighbouring timer, which the block finds itself. A second control bit lets the chosen events through or blocks them all, so the divider stops and holds its state.

The events drive a 4-bit down-counter. When the counter underflows, it reloads from a reload register, and software fills that register from a 4-bit accumulator with a write strobe. Each underflow flips a divide-by-two flop. With a reload value LC, the phase output is a square wave at source/(2·(LC+1)). A one-cycle pulse on each flip lets downstream logic run on the single system clock.

The block has no data stream, so every pin is a plain control or status pin. It has no valid/ready handshake and no back-pressure.

Top module: `lcd_clk_div`

## Requirements
- R1: While `rst_n` is low, and after it is released, `lcd_tick` and `lcd_phase` are 0, and the reload register and the counter hold 0. So the first count event allowed after reset underflows at once.
- R2: With `src_sel` = 1, each cycle that has `presc_tick` = 1 and `cnt_en` = 1 is one count event. `tmr_bit` has no effect in this mode.
- R3: With `src_sel` = 0, a count event happens in a cycle where `tmr_bit` is 1 and was 0 in the cycle before, with `cnt_en` = 1. Holding `tmr_bit` high gives only one event, and `presc_tick` has no effect in this mode.
- R4: While `cnt_en` = 0, no count event happens. The counter holds its value, `lcd_phase` stays unchanged and `lcd_tick` stays 0.
- R5: With reload value LC, consecutive `lcd_tick` pulses are exactly LC+1 count events apart. With a count event every cycle, they are LC+1 cycles apart.
- R6: `lcd_tick` is 1 in the cycle after a count event that finds the counter at 0, and only then. `lcd_phase` inverts in that same cycle and at no other time.
- R7: A pulse on `rld_wr` loads `acc_data` into the reload register and leaves the running count alone. The new value sets the spacing only from the next underflow on. If the write and an underflow fall in the same cycle, the old value is reloaded.
- R8: With LC = 0, every count event produces an `lcd_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Count source: 1 prescaler enable, 0 rising edge of timer bit |
| cnt_en | input | 1 | 1 lets count events through, 0 stops counting |
| presc_tick | input | 1 | One-cycle enable from the prescaler |
| tmr_bit | input | 1 | Level of the neighbouring timer's bit 4 |
| acc_data | input | 4 | Accumulator value for the reload register |
| rld_wr | input | 1 | Write strobe for the reload register |
| lcd_tick | output | 1 | One-cycle pulse on each flip of the divide-by-two stage |
| lcd_phase | output | 1 | Divide-by-two output, the LCD clock level |

## Verification
A corrupted counter or reload register shows at the ports as a wrong gap between `lcd_tick` pulses. The error is visible no later than the next underflow, at most sixteen count events away. A lost or extra flip of the divide-by-two flop makes `lcd_phase` change without a matching `lcd_tick`, or pulse without a change, within the same cycle. A broken timer-bit edge detector shows up as extra pulses while the timer bit is held high. The bench compares both outputs to a cycle model on every cycle, so any of these faults is caught in the cycle it first reaches a port.

// File: rtl/lcdclk_pkg.sv
package lcdclk_pkg;
  typedef enum logic {
    SRC_TIMER = 1'b0,
    SRC_PRESC = 1'b1
  } src_sel_e;

  localparam int unsigned LCD_CNT_W = 4;
endpackage

// File: rtl/lcdclk_src_gate.sv
// Picks the count source, finds timer-bit rising edges and applies the run gate.
module lcdclk_src_gate
  import lcdclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic cnt_en,
  input  logic presc_tick,
  input  logic tmr_bit,
  output logic cnt_ev
);
  logic     tmr_q;
  logic     tmr_rise;
  src_sel_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= 1'b0;
    else        tmr_q <= tmr_bit;
  end

  assign tmr_rise = tmr_bit & ~tmr_q;
  assign src      = src_sel_e'(src_sel);

  always_comb begin
    unique case (src)
      SRC_PRESC: cnt_ev = cnt_en & presc_tick;
      default:   cnt_ev = cnt_en & tmr_rise;
    endcase
  end
endmodule

// File: rtl/lcdclk_reload_cnt.sv
// Reload register and down-counter; flags the underflowing event.
module lcdclk_reload_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_ev,
  input  logic [CNT_W-1:0] acc_data,
  input  logic             rld_wr,
  output logic             uflow
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rld_q <= ZERO;
    else if (rld_wr) rld_q <= acc_data;
  end

  assign uflow = cnt_ev && (cnt_q == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (uflow)  cnt_q <= rld_q;
    else if (cnt_ev) cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/lcdclk_halver.sv
// Divide-by-two flop plus a registered pulse on each flip.
module lcdclk_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic uflow,
  output logic phase,
  output logic tick
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      tick  <= 1'b0;
    end else begin
      tick <= uflow;
      if (uflow) phase <= ~phase;
    end
  end
endmodule

// File: rtl/lcd_clk_div.sv
module lcd_clk_div
  import lcdclk_pkg::*;
#(
  parameter int unsigned CNT_W = LCD_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             cnt_en,
  input  logic             presc_tick,
  input  logic             tmr_bit,
  input  logic [CNT_W-1:0] acc_data,
  input  logic             rld_wr,
  output logic             lcd_tick,
  output logic             lcd_phase
);
  logic cnt_ev;
  logic uflow;

  lcdclk_src_gate u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .cnt_en     (cnt_en),
    .presc_tick (presc_tick),
    .tmr_bit    (tmr_bit),
    .cnt_ev     (cnt_ev)
  );

  lcdclk_reload_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_ev   (cnt_ev),
    .acc_data (acc_data),
    .rld_wr   (rld_wr),
    .uflow    (uflow)
  );

  lcdclk_halver u_half (
    .clk   (clk),
    .rst_n (rst_n),
    .uflow (uflow),
    .phase (lcd_phase),
    .tick  (lcd_tick)
  );
endmodule

// File: rtl/lcd_clk_div_chk.sv
module lcd_clk_div_chk (
  input logic clk,
  input logic rst_n,
  input logic src_sel,
  input logic cnt_en,
  input logic presc_tick,
  input logic tmr_bit,
  input logic lcd_tick,
  input logic lcd_phase
);
  logic started_q = 1'b0;
  logic past_ok_q;
  logic tmr_seen_q;

  always_ff @(posedge clk) started_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok_q  <= 1'b0;
      tmr_seen_q <= 1'b0;
    end else begin
      past_ok_q  <= 1'b1;
      tmr_seen_q <= tmr_bit;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (started_q && !$past(rst_n)) |-> (!lcd_tick && !lcd_phase));

  assert_presc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(cnt_en && src_sel && !presc_tick)) |-> !lcd_tick);

  assert_timer_noedge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(cnt_en && !src_sel && !(tmr_bit && !tmr_seen_q))) |-> !lcd_tick);

  assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && !$past(cnt_en)) |-> (!lcd_tick && $stable(lcd_phase)));

  assert_tick_matches_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (lcd_tick == (lcd_phase != $past(lcd_phase))));
endmodule

bind lcd_clk_div lcd_clk_div_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_sel    (src_sel),
  .cnt_en     (cnt_en),
  .presc_tick (presc_tick),
  .tmr_bit    (tmr_bit),
  .lcd_tick   (lcd_tick),
  .lcd_phase  (lcd_phase)
);

// File: tb/lcd_clk_div_tb.sv
`timescale 1ns/1ps
module lcd_clk_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_sel = 1'b0;
  logic       cnt_en = 1'b0;
  logic       presc_tick = 1'b0;
  logic       tmr_bit = 1'b0;
  logic [3:0] acc_data = 4'd0;
  logic       rld_wr = 1'b0;
  logic       lcd_tick;
  logic       lcd_phase;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [3:0] m_cnt = 4'd0;
  logic [3:0] m_rld = 4'd0;
  logic       m_tmr = 1'b0;
  logic       m_phase = 1'b0;
  logic       m_tick = 1'b0;
  int         cyc = 0;
  int         last_tick_cyc = -1;
  int         last_gap = 0;

  always #2 clk = ~clk;

  lcd_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cnt_en(cnt_en),
    .presc_tick(presc_tick), .tmr_bit(tmr_bit), .acc_data(acc_data),
    .rld_wr(rld_wr), .lcd_tick(lcd_tick), .lcd_phase(lcd_phase)
  );

  function automatic logic model_event(logic sel, logic en, logic pt, logic tb, logic prev);
    return en && (sel ? pt : (tb && !prev));
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // apply inputs at the falling edge, advance the model, compare after the rising edge
  task automatic step(string req, logic sel, logic en, logic pt, logic tb,
                      logic wr, logic [3:0] d);
    logic ev, uf;
    @(negedge clk);
    src_sel = sel; cnt_en = en; presc_tick = pt; tmr_bit = tb;
    rld_wr = wr; acc_data = d;
    ev = model_event(sel, en, pt, tb, m_tmr);
    uf = ev && (m_cnt == 4'd0);
    m_tmr = tb;
    if (uf) m_cnt = m_rld;
    else if (ev) m_cnt = m_cnt - 4'd1;
    if (wr) m_rld = d;
    m_tick = uf;
    if (uf) m_phase = ~m_phase;
    @(posedge clk);
    #1;
    cyc++;
    check(req, "lcd_tick", int'(lcd_tick), int'(m_tick));
    check(req, "lcd_phase", int'(lcd_phase), int'(m_phase));
    if (lcd_tick) begin
      if (last_tick_cyc >= 0) last_gap = cyc - last_tick_cyc;
      last_tick_cyc = cyc;
    end
  endtask

  task automatic write_lc(logic [3:0] v);
    step("R7", src_sel, 1'b0, 1'b0, tmr_bit, 1'b1, v);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1cd5eed));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "lcd_tick in reset", int'(lcd_tick), 0);
    check("R1", "lcd_phase in reset", int'(lcd_phase), 0);
    @(negedge clk) rst_n = 1'b1;

    // R1: first allowed event after reset underflows at once (reload 0)
    step("R1", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R1", "first event underflows", int'(lcd_tick), 1);

    // R8: LC=0, every event ticks
    for (int i = 0; i < 6; i++) step("R8", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R8", "gap at LC=0", last_gap, 1);

    // R5: directed period with LC=5, events every cycle
    write_lc(4'd5);
    for (int i = 0; i < 20; i++) step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R5", "gap at LC=5", last_gap, 6);

    // R7: write mid-count, old period finishes, then new period
    write_lc(4'd2);
    for (int i = 0; i < 14; i++) step("R7", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R7", "gap after reload write", last_gap, 3);
    // write coinciding with events (and possibly underflow)
    for (int i = 0; i < 10; i++) step("R7", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4);
    for (int i = 0; i < 12; i++) step("R7", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R7", "gap after written 4", last_gap, 5);

    // R15 max LC
    write_lc(4'd15);
    for (int i = 0; i < 40; i++) step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R5", "gap at LC=15", last_gap, 16);

    // R3: timer edge source, held-high level counts once
    write_lc(4'd0);
    step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    for (int i = 0; i < 8; i++) step("R3", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0);
    for (int i = 0; i < 30; i++) step("R3", 1'b0, 1'b1, 1'(i % 2), 1'((i / 3) % 2), 1'b0, 4'd0);

    // R4: gate off while inputs churn
    for (int i = 0; i < 30; i++)
      step("R4", 1'(i % 2), 1'b0, 1'b1, 1'(i % 3 == 0), 1'b0, 4'd0);

    // random mix, model-checked every cycle
    for (int i = 0; i < 4000; i++) begin
      logic sel, en, pt, tb, wr;
      logic [3:0] d;
      sel = 1'($urandom_range(0, 1));
      en  = ($urandom_range(0, 7) != 0);
      pt  = ($urandom_range(0, 2) == 0);
      tb  = 1'($urandom_range(0, 1));
      wr  = ($urandom_range(0, 40) == 0);
      d   = 4'($urandom_range(0, 15));
      step(sel ? "R2" : "R3", sel, en, pt, tb, wr, d);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule